// File: doc/BRIEF.md
# Two-Wire Target Command Decoder

This block is the serial front end of a two-channel register device. It sits on a fast system clock, oversamples the two-wire bus lines through synchronizers, and recognises START, repeated START and STOP from SDA edges that occur while SCL is high. When its 7-bit address is seen, it acknowledges the address. It then takes in a command byte and, for writes, a data byte. It hands the decoded operation to a register bank as a one-cycle strobe.

Every transaction follows a fixed three-byte frame: address, command, data. A write reaches the bank only when the last data bit has been clocked in, so a frame cut short leaves the bank untouched. Reads work in two steps. A write-direction frame first sets a read pointer, which the bank sees on its select outputs. A read-direction address then returns one byte from the bank, MSB first.

The bus output is open-drain and is modelled as an enable that pulls SDA low. The bank can refuse new traffic through a busy input.

Top module: `i2c_cmd_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal binary 010 followed by the four strap inputs (strap bit 3 first). Bit 0 of the byte is the direction: 0 means write, 1 means read. Any other address, including the all-zero general call, gets no acknowledge, and the rest of that frame produces no strobe.
- R2: While the bank busy input is high at the eighth address bit, a matching address is not acknowledged.
- R3: A write command sets command bits 7:6 = 00, bits 5:4 (the destination: bit 4 = volatile, bit 5 = nonvolatile) not 00, and bits 3:0 as the register. The cycle after the eighth data bit's SCL rise (the 26th rise of the frame), it raises the strobe with transfer flag 0, the destination, the register and the data byte, MSB first.
- R4: A write cut off by a STOP or a START before the eighth data bit's rise produces no strobe.
- R5: A transfer command (bits 7:6 = 00, bits 5:4 = 00) raises the strobe with the transfer flag set, destination 00, data 00 and its register. It fires on the STOP that directly follows the command byte's acknowledge. A START at that point, or a second data clock, drops it.
- R6: A read-select command (bits 7:6 = 10, destination 01 or 10, register not 1111) loads the read pointer onto the select outputs. A later read-direction address returns the bank byte for that pointer, MSB first, and releases SDA on the master's acknowledge clock.
- R7: The target acknowledges any other command encoding, as well as every data byte that follows it. Such a command produces no strobe and leaves the read pointer unchanged.
- R8: Register 1111 (all channels) is accepted only with destination 01 in a write. With any other destination or class, it is treated as undefined.
- R9: A STOP inside the same SCL high period as a START is ignored, and the frame that follows proceeds.
- R10: The target acknowledges the address, command and data bytes of a frame by pulling SDA low through the ninth clock, and it changes the SDA enable only while SCL is low.
- R11: After reset, the SDA enable and the strobe are low and the read pointer is zero.
- R12: Each strobe lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 4 | Board straps forming the low address bits |
| bank_busy_i | input | 1 | Bank busy; matching addresses are refused while high |
| cmd_valid_o | output | 1 | One-cycle operation strobe |
| cmd_xfer_o | output | 1 | 1 = nonvolatile-to-volatile transfer, 0 = write |
| cmd_dst_o | output | 2 | Destination select, bit 0 volatile, bit 1 nonvolatile |
| cmd_reg_o | output | 4 | Register select |
| cmd_data_o | output | 8 | Write data |
| rd_dst_o | output | 2 | Read pointer destination |
| rd_reg_o | output | 4 | Read pointer register |
| rd_data_i | input | 8 | Bank byte for the current read pointer |

## Verification
The properties take for granted that every SCL high and low phase lasts well beyond the synchronizer depth plus two system clocks. This lets each bus event land in its own cycle and keeps SCL steady for a few cycles after any edge. They also take for granted that SDA moves while SCL is high only for a deliberate START or STOP. The bench master holds every quarter of a bit for ten system clocks and changes SDA only in the low phase, except in its START, STOP and illegal START-STOP sequences. It drives the bus as a wired-AND of its own SDA and the target's pull-down.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_BITS = 8;

  localparam logic [1:0] DST_NONE = 2'b00;
  localparam logic [1:0] DST_VOL  = 2'b01;
  localparam logic [1:0] DST_NV   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_RDATA,
    ST_HOLD
  } eng_state_t;

  typedef struct packed {
    logic       is_write;
    logic       is_xfer;
    logic       is_rdsel;
    logic [1:0] dst;
    logic [3:0] regsel;
  } cmd_dec_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  logic scl_d, sda_d, start_seen;

  assign scl_o      = lvl[1];
  assign sda_o      = lvl[0];
  assign scl_rise_o = lvl[1] & ~scl_d;
  assign scl_fall_o = ~lvl[1] & scl_d;
  assign start_o    = lvl[1] & scl_d & sda_d & ~lvl[0];
  assign stop_o     = lvl[1] & scl_d & ~sda_d & lvl[0] & ~start_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      start_seen <= 1'b0;
    end else begin
      scl_d <= lvl[1];
      sda_d <= lvl[0];
      if (start_o)         start_seen <= 1'b1;
      else if (scl_fall_o) start_seen <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_BITS-1:0] cmd_i,
  output cmd_dec_t             dec_o
);

  logic [1:0] cls;
  logic [1:0] dst;
  logic [3:0] rsel;
  logic       all_sel;
  logic       all_ok;

  assign cls     = cmd_i[7:6];
  assign dst     = cmd_i[5:4];
  assign rsel    = cmd_i[3:0];
  assign all_sel = (rsel == 4'hF);
  assign all_ok  = !all_sel || (dst == DST_VOL);

  always_comb begin
    dec_o.dst      = dst;
    dec_o.regsel   = rsel;
    dec_o.is_write = (cls == 2'b00) && (dst != DST_NONE) && all_ok;
    dec_o.is_xfer  = (cls == 2'b00) && (dst == DST_NONE) && all_ok;
    dec_o.is_rdsel = (cls == 2'b10) && ((dst == DST_VOL) || (dst == DST_NV)) && !all_sel;
  end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter int                 PREFIX_W = 3,
  parameter logic [PREFIX_W-1:0] PREFIX  = 3'b010,
  parameter int                 STRAP_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start,
  input  logic               stop,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [7:0]         rd_data_i,
  output logic               sda_oe_o,
  output logic               cmd_valid_o,
  output logic               cmd_xfer_o,
  output logic [1:0]         cmd_dst_o,
  output logic [3:0]         cmd_reg_o,
  output logic [7:0]         cmd_data_o,
  output logic [1:0]         rd_dst_o,
  output logic [3:0]         rd_reg_o
);

  localparam int ADDR_W = PREFIX_W + STRAP_W;
  localparam int CNT_W  = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS);

  eng_state_t           st;
  logic [CNT_W-1:0]     bitcnt;
  logic [BYTE_BITS-1:0] shreg;
  logic [BYTE_BITS-1:0] byte_now;
  logic                 ack_q;
  logic                 rw_q;
  cmd_dec_t             cmd_q;
  cmd_dec_t             dec;
  logic [ADDR_W-1:0]    own_addr;

  assign byte_now = {shreg[BYTE_BITS-2:0], sda_s};
  assign own_addr = {PREFIX, strap_i};

  i2c_cmd_decode u_dec (
    .cmd_i (byte_now),
    .dec_o (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      ack_q       <= 1'b0;
      rw_q        <= 1'b0;
      cmd_q       <= '0;
      sda_oe_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_xfer_o  <= 1'b0;
      cmd_dst_o   <= '0;
      cmd_reg_o   <= '0;
      cmd_data_o  <= '0;
      rd_dst_o    <= '0;
      rd_reg_o    <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (start) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        ack_q    <= 1'b0;
        cmd_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop) begin
        if (st == ST_DATA && bitcnt <= CNT_W'(1) && cmd_q.is_xfer) begin
          cmd_valid_o <= 1'b1;
          cmd_xfer_o  <= 1'b1;
          cmd_dst_o   <= DST_NONE;
          cmd_reg_o   <= cmd_q.regsel;
          cmd_data_o  <= '0;
        end
        st       <= ST_IDLE;
        ack_q    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (scl_rise) begin
        unique case (st)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (bitcnt != ACK_SLOT) begin
              shreg  <= byte_now;
              bitcnt <= bitcnt + 1'b1;
              if (st == ST_DATA && bitcnt == CNT_W'(1)) cmd_q.is_xfer <= 1'b0;
              if (bitcnt == LAST_BIT) begin
                unique case (st)
                  ST_ADDR: begin
                    ack_q <= (byte_now[BYTE_BITS-1:1] == own_addr) && !busy_i;
                    rw_q  <= byte_now[0];
                  end
                  ST_CMD: begin
                    ack_q <= 1'b1;
                    cmd_q <= dec;
                    if (dec.is_rdsel) begin
                      rd_dst_o <= dec.dst;
                      rd_reg_o <= dec.regsel;
                    end
                  end
                  default: begin
                    ack_q <= 1'b1;
                    if (cmd_q.is_write) begin
                      cmd_valid_o <= 1'b1;
                      cmd_xfer_o  <= 1'b0;
                      cmd_dst_o   <= cmd_q.dst;
                      cmd_reg_o   <= cmd_q.regsel;
                      cmd_data_o  <= byte_now;
                    end
                  end
                endcase
              end
            end else begin
              bitcnt <= '0;
              ack_q  <= 1'b0;
              unique case (st)
                ST_ADDR: begin
                  if (!ack_q)    st <= ST_IDLE;
                  else if (rw_q) begin
                    st    <= ST_RDATA;
                    shreg <= rd_data_i;
                  end else       st <= ST_CMD;
                end
                ST_CMD:  st <= ST_DATA;
                default: st <= ST_HOLD;
              endcase
            end
          end
          ST_RDATA: begin
            if (bitcnt != ACK_SLOT) begin
              shreg  <= {shreg[BYTE_BITS-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end else begin
              st     <= ST_HOLD;
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        if (st == ST_RDATA) sda_oe_o <= (bitcnt != ACK_SLOT) && !shreg[BYTE_BITS-1];
        else                sda_oe_o <= (bitcnt == ACK_SLOT) && ack_q;
      end
    end
  end

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_tgt_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter int                  PREFIX_W    = 3,
  parameter logic [PREFIX_W-1:0] PREFIX      = 3'b010,
  parameter int                  STRAP_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               bank_busy_i,
  output logic               cmd_valid_o,
  output logic               cmd_xfer_o,
  output logic [1:0]         cmd_dst_o,
  output logic [3:0]         cmd_reg_o,
  output logic [7:0]         cmd_data_o,
  output logic [1:0]         rd_dst_o,
  output logic [3:0]         rd_reg_o,
  input  logic [7:0]         rd_data_i
);

  logic scl_sync, sda_sync, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_sync),
    .sda_o      (sda_sync),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_byte_engine #(
    .PREFIX_W (PREFIX_W),
    .PREFIX   (PREFIX),
    .STRAP_W  (STRAP_W)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .sda_s       (sda_sync),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start       (bus_start),
    .stop        (bus_stop),
    .strap_i     (strap_i),
    .busy_i      (bank_busy_i),
    .rd_data_i   (rd_data_i),
    .sda_oe_o    (sda_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_xfer_o  (cmd_xfer_o),
    .cmd_dst_o   (cmd_dst_o),
    .cmd_reg_o   (cmd_reg_o),
    .cmd_data_o  (cmd_data_o),
    .rd_dst_o    (rd_dst_o),
    .rd_reg_o    (rd_reg_o)
  );

endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       cmd_valid_o,
  input logic       cmd_xfer_o,
  input logic [1:0] cmd_dst_o,
  input logic [3:0] cmd_reg_o,
  input logic [7:0] cmd_data_o
);

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_s);

  p_strobe_width_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  p_strobe_scl_high_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> scl_s);

  p_xfer_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_xfer_o) |-> (cmd_data_o == 8'h00 && cmd_dst_o == 2'b00));

  p_all_reg_vol_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_reg_o == 4'hF) |-> (cmd_dst_o == 2'b01 && !cmd_xfer_o));

endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .scl_s       (scl_sync),
  .sda_oe_o    (sda_oe_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_xfer_o  (cmd_xfer_o),
  .cmd_dst_o   (cmd_dst_o),
  .cmd_reg_o   (cmd_reg_o),
  .cmd_data_o  (cmd_data_o)
);

// File: tb/test_i2c_cmd_target.sv
module test_i2c_cmd_target;

  localparam int Q = 10;
  localparam logic [7:0] WA = 8'h54;
  localparam logic [7:0] RA = 8'h55;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, scl_m, sda_m, busy;
  logic [3:0] strap = 4'b1010;
  logic       sda_oe, cmd_valid, cmd_xfer;
  logic [1:0] cmd_dst, rd_dst;
  logic [3:0] cmd_reg, rd_reg;
  logic [7:0] cmd_data, rd_data;
  wire        sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] bank_val(input logic [1:0] d, input logic [3:0] r);
    return {d, 2'b01, r} ^ 8'h5A;
  endfunction
  assign rd_data = bank_val(rd_dst, rd_reg);

  i2c_cmd_target i_i2c_cmd_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .bank_busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_xfer_o(cmd_xfer),
    .cmd_dst_o(cmd_dst), .cmd_reg_o(cmd_reg), .cmd_data_o(cmd_data),
    .rd_dst_o(rd_dst), .rd_reg_o(rd_reg), .rd_data_i(rd_data)
  );

  typedef struct {
    logic [14:0] v;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  bit   prev_valid = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic x, input logic [1:0] d, input logic [3:0] r,
                          input logic [7:0] v, input string tag);
    exp_t e;
    e.v = {x, d, r, v};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      logic [14:0] got;
      got = {cmd_xfer, cmd_dst, cmd_reg, cmd_data};
      chk(!prev_valid, "R12 strobe width", 32'(prev_valid), 0);
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe", 32'(got), 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(got == e.v, e.tag, 32'(got), 32'(e.v));
      end
    end
    prev_valid = cmd_valid;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit released);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    tick(Q);
    scl_m = 1'b1; tick(Q);
    released = !sda_oe;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr3(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                     output bit k0, output bit k1, output bit k2);
    bus_start;
    send_byte(a, k0);
    send_byte(c, k1);
    send_byte(d, k2);
    bus_stop;
  endtask

  task automatic drained(input string tag);
    tick(4);
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit k0, k1, k2, rel;
    logic [7:0] rb;
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R11 reset state
    chk(sda_oe == 1'b0, "R11 sda enable", 32'(sda_oe), 0);
    chk(cmd_valid == 1'b0, "R11 strobe", 32'(cmd_valid), 0);
    chk(rd_dst == 2'b00 && rd_reg == 4'h0, "R11 read pointer", 32'({rd_dst, rd_reg}), 0);

    // R1 R3 R10: volatile write, then both-destination write
    push_exp(1'b0, 2'b01, 4'h0, 8'hA5, "R3 volatile write");
    wr3(WA, 8'h10, 8'hA5, k0, k1, k2);
    chk(k0, "R1 address ack", 32'(k0), 1);
    chk(k1 && k2, "R10 command and data ack", 32'({k1, k2}), 3);
    drained("R3 volatile write drained");
    push_exp(1'b0, 2'b11, 4'h1, 8'h3C, "R3 dual write");
    wr3(WA, 8'h31, 8'h3C, k0, k1, k2);
    drained("R3 dual write drained");

    // R1 wrong address and general call
    wr3(8'h56, 8'h10, 8'h77, k0, k1, k2);
    chk(!k0, "R1 mismatch nack", 32'(k0), 0);
    drained("R1 mismatch no strobe");
    bus_start;
    send_byte(8'h00, k0);
    bus_stop;
    chk(!k0, "R1 general call nack", 32'(k0), 0);

    // R2 busy
    busy = 1'b1;
    bus_start;
    send_byte(WA, k0);
    bus_stop;
    busy = 1'b0;
    chk(!k0, "R2 busy nack", 32'(k0), 0);

    // R4 aborted writes
    bus_start;
    send_byte(WA, k0);
    send_byte(8'h10, k1);
    send_bits(8'hFF, 4);
    bus_stop;
    drained("R4 stop abort");
    push_exp(1'b0, 2'b01, 4'h1, 8'h5A, "R4 write after start abort");
    bus_start;
    send_byte(WA, k0);
    send_byte(8'h11, k1);
    send_bits(8'h00, 6);
    wr3(WA, 8'h11, 8'h5A, k0, k1, k2);
    drained("R4 start abort");

    // R5 transfer, then transfer dropped by repeated START
    push_exp(1'b1, 2'b00, 4'h1, 8'h00, "R5 transfer");
    bus_start;
    send_byte(WA, k0);
    send_byte(8'h01, k1);
    bus_stop;
    chk(k1, "R5 transfer command ack", 32'(k1), 1);
    drained("R5 transfer drained");
    push_exp(1'b0, 2'b01, 4'h0, 8'h11, "R5 only write after dropped transfer");
    bus_start;
    send_byte(WA, k0);
    send_byte(8'h04, k1);
    wr3(WA, 8'h10, 8'h11, k0, k1, k2);
    drained("R5 dropped transfer");

    // R6 reads
    bus_start;
    send_byte(WA, k0);
    send_byte(8'h91, k1);
    chk(rd_dst == 2'b01 && rd_reg == 4'h1, "R6 pointer volatile 1", 32'({rd_dst, rd_reg}), 32'({2'b01, 4'h1}));
    bus_start;
    send_byte(RA, k0);
    chk(k0, "R6 read address ack", 32'(k0), 1);
    recv_byte(rb, rel);
    bus_stop;
    chk(rb == bank_val(2'b01, 4'h1), "R6 read byte", 32'(rb), 32'(bank_val(2'b01, 4'h1)));
    chk(rel, "R6 release on master ack", 32'(rel), 1);
    bus_start;
    send_byte(WA, k0);
    send_byte(8'hA4, k1);
    bus_start;
    send_byte(RA, k0);
    recv_byte(rb, rel);
    bus_stop;
    chk(rb == bank_val(2'b10, 4'h4), "R6 read nonvolatile 4", 32'(rb), 32'(bank_val(2'b10, 4'h4)));

    // R7 undefined commands
    bus_start;
    send_byte(WA, k0);
    send_byte(8'hB1, k1);
    bus_stop;
    chk(k1, "R7 undefined read ack", 32'(k1), 1);
    chk(rd_dst == 2'b10 && rd_reg == 4'h4, "R7 pointer unchanged", 32'({rd_dst, rd_reg}), 32'({2'b10, 4'h4}));
    wr3(WA, 8'h40, 8'h99, k0, k1, k2);
    chk(k1 && k2, "R7 undefined write acked", 32'({k1, k2}), 3);
    drained("R7 undefined no strobe");

    // R8 all-register code
    wr3(WA, 8'h2F, 8'h12, k0, k1, k2);
    drained("R8 nonvolatile all ignored");
    push_exp(1'b0, 2'b01, 4'hF, 8'h77, "R8 volatile all write");
    wr3(WA, 8'h1F, 8'h77, k0, k1, k2);
    drained("R8 volatile all drained");

    // R9 STOP in the same high period as START
    push_exp(1'b0, 2'b01, 4'h0, 8'h42, "R9 frame after illegal stop");
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    send_byte(WA, k0);
    send_byte(8'h10, k1);
    send_byte(8'h42, k2);
    bus_stop;
    chk(k0, "R9 address ack after illegal stop", 32'(k0), 1);
    drained("R9 illegal stop ignored");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule